// File: doc/BRIEF.md
# SECDED Protected RAM Wrapper

This block puts single-error-correct, double-error-detect protection around an on-chip word RAM for a 32-bit processor port with byte lanes. Each stored word is 39 bits wide: 32 data bits plus 7 check bits. Writes that cover every lane are encoded and stored in one cycle. Reads are checked and corrected on the way out, and the check bits are never returned. Writes that cover only some lanes run as an internal read, correct, merge, re-encode and write sequence. The request port stalls for that extra cycle.

Every detected error produces a record in a small circular log that is kept apart from the protected data. A correctable error pulses an interrupt line. An uncorrectable error pulses a reset request and does not hand back data as valid. A fault-injection mask flips chosen code-word bits on the write path, so that test logic can exercise the checker. When scrubbing is enabled, a read that found a single-bit error writes the corrected word back.

Requests use valid/ready. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold its request fields stable while `req_valid` is high and `req_ready` is low. Responses carry no back-pressure: `rsp_valid` is a one-cycle pulse that the requester must take. Every accepted request yields exactly one response, in acceptance order.

Top module: `eccmem_top`

## Requirements
- R1: A write with all four lanes enabled (`req_be`=4'hF) is stored in the accepting cycle. Its response (`rsp_valid`=1, `rsp_err`=0, `rsp_rdata`=0) appears in the cycle after acceptance, and `req_ready` stays high, so that back-to-back full writes are possible.
- R2: A read returns the stored 32 data bits on `rsp_rdata` two cycles after acceptance. `req_ready` is low in the cycle after acceptance.
- R3: A write with some but not all lanes enabled keeps the unselected bytes, corrected if needed, and replaces only the bytes whose `req_be` bit is set (bit n covers data bits 8n+7..8n). `req_ready` is low in the cycle after acceptance. The response (`rsp_rdata`=0) comes two cycles after acceptance.
- R4: The stored word layout is as follows. Bit 0 is the overall parity of the word. Bits 1..38 are Hamming positions 1..38, with check bits at 1, 2, 4, 8, 16 and 32. The 7-bit syndrome is {overall parity mismatch, XOR of the positions holding a one}. A single flip at bit k therefore gives {1, k}. A double flip at bits a and b gives {0, a^b}.
- R5: A stored word with one flipped bit is returned with the correct data and `rsp_err`=0. A one-cycle `ce_irq` pulse is raised in the same cycle as the response.
- R6: A word with two flipped bits gives a response with `rsp_err`=1 and `rsp_rdata`=0, and a one-cycle `ue_rst_req` pulse with no `ce_irq`. A partial write that meets such a word leaves the stored word unchanged.
- R7: Each correctable or uncorrectable error writes {address, syndrome, double flag} into the log entry at `log_wptr`. The pointer advances in the same cycle as the interrupt or reset pulse, and wraps modulo 16. `log_rd_idx` reads any entry combinationally.
- R8: `inj_mask` is XORed into the encoded word of every write that comes from a request, whether a full write or the write phase of a partial write. It is sampled at acceptance.
- R9: With `scrub_en`=1, a read that corrected a single error writes the corrected word back. With `scrub_en`=0 the word is left as it is. A read with a double error never writes back.
- R10: After reset, `req_ready`=1, `rsp_valid`=0, `ce_irq`=0, `ue_rst_req`=0 and `log_wptr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready; low while a read or partial write finishes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane enables |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data; zero for writes and uncorrectable reads |
| rsp_err | output | 1 | Response carries an uncorrectable error |
| inj_mask | input | 39 | Code-word bits to flip on request writes |
| scrub_en | input | 1 | Write back corrected words on reads |
| ce_irq | output | 1 | Correctable-error interrupt pulse |
| ue_rst_req | output | 1 | Uncorrectable-error reset request pulse |
| log_rd_idx | input | 4 | Log entry to read |
| log_rd_addr | output | ADDR_W | Address of the selected log entry |
| log_rd_syn | output | 7 | Syndrome of the selected log entry |
| log_rd_dbl | output | 1 | Selected entry was uncorrectable |
| log_wptr | output | 4 | Next log entry to be written |

## Verification
A full write answers one cycle after its acceptance edge. A read or partial write answers two cycles after it, and any `ce_irq` or `ue_rst_req` pulse arrives in that same cycle, together with the log pointer step. `req_ready` must read low in the cycle directly after a read or partial write is accepted. The driver stamps each expected item with the cycle count in which its response is due. The monitor compares that stamp, the data, the error flag and both pulses whenever `rsp_valid` is seen on a falling edge. Log contents and the pointer are read through the log port once the matching response has passed.

// File: rtl/eccmem_pkg.sv
package eccmem_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 39;
  localparam int SYN_W  = 7;

  typedef enum logic {ST_IDLE, ST_CHK} eccmem_state_e;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // place data bits on non-power-of-two positions, then fill check bits
  function automatic logic [CODE_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    logic x;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        c[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < SYN_W - 1; i++) begin
      x = 1'b0;
      for (int p = 1; p < CODE_W; p++) if (p[i]) x ^= c[p];
      c[1 << i] = x;
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic logic [SYN_W-2:0] ecc_position(input logic [CODE_W-1:0] c);
    logic [SYN_W-2:0] s;
    s = '0;
    for (int p = 1; p < CODE_W; p++) if (c[p]) s ^= p[SYN_W-2:0];
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] ecc_extract(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        d[k] = c[p];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/eccmem_enc.sv
module eccmem_enc
  import eccmem_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  input  logic [CODE_W-1:0] flip_mask,
  output logic [CODE_W-1:0] code_out
);
  always_comb code_out = ecc_encode(data_in) ^ flip_mask;
endmodule

// File: rtl/eccmem_dec.sv
module eccmem_dec
  import eccmem_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_fix,
  output logic [DATA_W-1:0] data_fix,
  output logic [SYN_W-1:0]  syndrome,
  output logic              err_single,
  output logic              err_double
);
  logic [SYN_W-2:0] pos;
  logic             par;

  always_comb begin
    pos        = ecc_position(code_in);
    par        = ^code_in;
    syndrome   = {par, pos};
    err_single = 1'b0;
    err_double = 1'b0;
    code_fix   = code_in;
    if (par) begin
      if (pos <= (SYN_W-1)'(CODE_W - 1)) begin
        err_single = 1'b1;
        code_fix   = code_in ^ (CODE_W'(1) << pos);
      end else begin
        err_double = 1'b1;
      end
    end else if (pos != '0) begin
      err_double = 1'b1;
    end
    data_fix = ecc_extract(code_fix);
  end
endmodule

// File: rtl/eccmem_ram.sv
module eccmem_ram #(
  parameter int ADDR_W = 6,
  parameter int WIDTH  = 39,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/eccmem_log.sv
module eccmem_log #(
  parameter int ADDR_W = 6,
  parameter int SYN_W  = 7,
  parameter int DEPTH  = 16,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SYN_W-1:0]  wr_syn,
  input  logic              wr_dbl,
  input  logic [IW-1:0]     rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [SYN_W-1:0]  rd_syn,
  output logic              rd_dbl,
  output logic [IW-1:0]     wptr
);
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [SYN_W-1:0]  syn_mem  [DEPTH];
  logic              dbl_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (wr_en) begin
      addr_mem[wptr] <= wr_addr;
      syn_mem[wptr]  <= wr_syn;
      dbl_mem[wptr]  <= wr_dbl;
      wptr           <= wptr + 1'b1;
    end
  end

  always_comb begin
    rd_addr = addr_mem[rd_idx];
    rd_syn  = syn_mem[rd_idx];
    rd_dbl  = dbl_mem[rd_idx];
  end
endmodule

// File: rtl/eccmem_top.sv
module eccmem_top
  import eccmem_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LOG_DEPTH = 16,
  localparam int LOG_IW   = $clog2(LOG_DEPTH),
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic [CODE_W-1:0] inj_mask,
  input  logic              scrub_en,
  output logic              ce_irq,
  output logic              ue_rst_req,
  input  logic [LOG_IW-1:0] log_rd_idx,
  output logic [ADDR_W-1:0] log_rd_addr,
  output logic [SYN_W-1:0]  log_rd_syn,
  output logic              log_rd_dbl,
  output logic [LOG_IW-1:0] log_wptr
);
  eccmem_state_e     state;
  logic              accept, full_wr, in_chk;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, merged, enc_data;
  logic [LANES-1:0]  be_q;
  logic              wr_q;
  logic [CODE_W-1:0] inj_q, enc_flip, enc_code;
  logic              ram_we, ram_re;
  logic [ADDR_W-1:0] ram_waddr;
  logic [CODE_W-1:0] ram_wdata, ram_rdata;
  logic [CODE_W-1:0] dec_code;
  logic [DATA_W-1:0] dec_data;
  logic [SYN_W-1:0]  dec_syn;
  logic              dec_ce, dec_ue;

  assign req_ready = (state == ST_IDLE);
  assign in_chk    = (state == ST_CHK);
  assign accept    = req_valid && req_ready;
  assign full_wr   = req_write && (&req_be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (accept && !full_wr) begin
      state <= ST_CHK;
    end else if (in_chk) begin
      state <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      wr_q    <= req_write;
      inj_q   <= inj_mask;
    end
  end

  // lane merge for partial writes: new byte where enabled, corrected old byte otherwise
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[8*l +: 8] = be_q[l] ? wdata_q[8*l +: 8] : dec_data[8*l +: 8];
  end

  assign enc_data = in_chk ? merged : req_wdata;
  assign enc_flip = in_chk ? inj_q  : inj_mask;

  eccmem_enc u_enc (
    .data_in  (enc_data),
    .flip_mask(enc_flip),
    .code_out (enc_code)
  );

  eccmem_dec u_dec (
    .code_in   (ram_rdata),
    .code_fix  (dec_code),
    .data_fix  (dec_data),
    .syndrome  (dec_syn),
    .err_single(dec_ce),
    .err_double(dec_ue)
  );

  always_comb begin
    ram_re    = accept && !full_wr;
    ram_we    = 1'b0;
    ram_waddr = req_addr;
    ram_wdata = enc_code;
    if (in_chk) begin
      ram_waddr = addr_q;
      if (wr_q) begin
        ram_we = !dec_ue;
      end else begin
        ram_we    = dec_ce && scrub_en;
        ram_wdata = dec_code;
      end
    end else begin
      ram_we = accept && full_wr;
    end
  end

  eccmem_ram #(.ADDR_W(ADDR_W), .WIDTH(CODE_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (ram_re),
    .raddr(req_addr),
    .rdata(ram_rdata)
  );

  eccmem_log #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .DEPTH(LOG_DEPTH)) u_log (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (in_chk && (dec_ce || dec_ue)),
    .wr_addr(addr_q),
    .wr_syn (dec_syn),
    .wr_dbl (dec_ue),
    .rd_idx (log_rd_idx),
    .rd_addr(log_rd_addr),
    .rd_syn (log_rd_syn),
    .rd_dbl (log_rd_dbl),
    .wptr   (log_wptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
      ce_irq     <= 1'b0;
      ue_rst_req <= 1'b0;
    end else begin
      rsp_valid  <= (accept && full_wr) || in_chk;
      rsp_rdata  <= (in_chk && !wr_q && !dec_ue) ? dec_data : '0;
      rsp_err    <= in_chk && dec_ue;
      ce_irq     <= in_chk && dec_ce;
      ue_rst_req <= in_chk && dec_ue;
    end
  end
endmodule

// File: rtl/eccmem_chk.sv
module eccmem_chk #(
  parameter int LIW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_write,
  input logic [3:0]     req_be,
  input logic           rsp_valid,
  input logic [31:0]    rsp_rdata,
  input logic           rsp_err,
  input logic           ce_irq,
  input logic           ue_rst_req,
  input logic [LIW-1:0] log_wptr
);
  logic acc_full, acc_slow;
  assign acc_full = req_valid && req_ready && req_write && (&req_be);
  assign acc_slow = req_valid && req_ready && !(req_write && (&req_be));

  p_full_write_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_full |=> rsp_valid && !rsp_err && rsp_rdata == '0 && req_ready);

  p_stall_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_slow |=> !req_ready && !rsp_valid);

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_slow && !req_write) |=> ##1 rsp_valid);

  p_rmw_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_slow && req_write) |=> ##1 (rsp_valid && rsp_rdata == '0));

  p_ce_with_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_irq |-> rsp_valid && !rsp_err && !ue_rst_req);

  p_ue_hides_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ue_rst_req |-> rsp_valid && rsp_err && rsp_rdata == '0);

  p_log_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_irq || ue_rst_req) |-> log_wptr == LIW'($past(log_wptr) + 1'b1));

  p_log_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce_irq || ue_rst_req) |-> $stable(log_wptr));
endmodule

bind eccmem_top eccmem_chk #(.LIW($clog2(LOG_DEPTH))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_be    (req_be),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .ce_irq    (ce_irq),
  .ue_rst_req(ue_rst_req),
  .log_wptr  (log_wptr)
);

// File: tb/eccmem_top_tb.sv
`timescale 1ns/1ps
module eccmem_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, scrub_en = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic [38:0] inj_mask = '0;
  logic [3:0]  log_rd_idx = '0;
  logic        req_ready, rsp_valid, rsp_err, ce_irq, ue_rst_req, log_rd_dbl;
  logic [31:0] rsp_rdata;
  logic [5:0]  log_rd_addr;
  logic [6:0]  log_rd_syn;
  logic [3:0]  log_wptr;

  eccmem_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .inj_mask(inj_mask), .scrub_en(scrub_en), .ce_irq(ce_irq), .ue_rst_req(ue_rst_req),
    .log_rd_idx(log_rd_idx), .log_rd_addr(log_rd_addr), .log_rd_syn(log_rd_syn),
    .log_rd_dbl(log_rd_dbl), .log_wptr(log_wptr)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] data;
    bit          err;
    bit          ce;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench model: intended data and the set of flipped stored bits per address
  logic [31:0] m_data  [64];
  logic [38:0] m_flips [64];
  logic [5:0]  lg_addr [16];
  logic [6:0]  lg_syn  [16];
  bit          lg_dbl  [16];
  int          exp_wptr = 0;

  // R4: syndrome of a flip pattern of one or two bits
  function automatic logic [6:0] flip_syn(input logic [38:0] f);
    logic [5:0] s;
    s = '0;
    for (int k = 1; k < 39; k++) if (f[k]) s ^= 6'(k);
    return {^f, s};
  endfunction

  task automatic do_req(input bit wr, input logic [5:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic [38:0] m, input string tag);
    exp_t e;
    int n;
    bit full;
    full = wr && (be == 4'hF);
    n = $countones(m_flips[a]);
    e.tag = tag;
    e.ce = (!full) && (n == 1);
    e.err = (!full) && (n == 2);
    e.data = (wr || n == 2) ? 32'h0 : m_data[a];
    if (!full && n > 0) begin
      lg_addr[exp_wptr] = a;
      lg_syn[exp_wptr] = flip_syn(m_flips[a]);
      lg_dbl[exp_wptr] = (n == 2);
      exp_wptr = (exp_wptr + 1) % 16;
    end
    if (full) begin
      m_data[a] = d;
      m_flips[a] = m;
    end else if (wr && n != 2) begin
      for (int l = 0; l < 4; l++) if (be[l]) m_data[a][8*l +: 8] = d[8*l +: 8];
      m_flips[a] = m;
    end else if (!wr && n == 1 && scrub_en) begin
      m_flips[a] = '0;
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be; inj_mask = m;
    while (!req_ready) @(negedge clk);
    e.due = cyc + (full ? 1 : 2);
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    check(req_ready == full, {tag, " R2/R3 ready after accept"}, 64'(req_ready), 64'(full));
    req_valid = 1'b0; inj_mask = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_last_log(input string tag);
    int idx;
    idle(2);
    idx = (exp_wptr + 15) % 16;
    log_rd_idx = 4'(idx);
    #1;
    check(log_rd_addr == lg_addr[idx], {tag, " R7 log addr"}, 64'(log_rd_addr), 64'(lg_addr[idx]));
    check(log_rd_syn == lg_syn[idx], {tag, " R4 log syndrome"}, 64'(log_rd_syn), 64'(lg_syn[idx]));
    check(log_rd_dbl == lg_dbl[idx], {tag, " R7 log double flag"}, 64'(log_rd_dbl), 64'(lg_dbl[idx]));
    check(log_wptr == 4'(exp_wptr), {tag, " R7 log pointer"}, 64'(log_wptr), 64'(exp_wptr));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "unexpected response", 64'(rsp_rdata), 64'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, {e.tag, " R1/R2/R3 response cycle"}, 64'(cyc), 64'(e.due));
          check(rsp_rdata == e.data, {e.tag, " R2/R5 data"}, 64'(rsp_rdata), 64'(e.data));
          check(rsp_err == e.err && ue_rst_req == e.err, {e.tag, " R6 err/reset request"},
                64'({rsp_err, ue_rst_req}), 64'({e.err, e.err}));
          check(ce_irq == e.ce, {e.tag, " R5 ce_irq"}, 64'(ce_irq), 64'(e.ce));
        end
      end else if (ce_irq || ue_rst_req) begin
        check(1'b0, "R5/R6 pulse without response", 64'({ce_irq, ue_rst_req}), 64'h0);
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog expired", 64'(cyc), 64'h0);
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_data[i] = '0; m_flips[i] = '0; end
    idle(4);
    check(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'h1);
    check(rsp_valid == 1'b0 && ce_irq == 1'b0 && ue_rst_req == 1'b0, "R10 outputs quiet in reset",
          64'({rsp_valid, ce_irq, ue_rst_req}), 64'h0);
    rst_n = 1'b1;
    idle(1);
    check(log_wptr == 4'd0, "R10 log pointer", 64'(log_wptr), 64'h0);

    // R1 back-to-back full writes, R2 reads
    do_req(1, 6'd1, 32'hDEADBEEF, 4'hF, '0, "R1 full write a1");
    do_req(1, 6'd2, 32'h11223344, 4'hF, '0, "R1 full write a2");
    do_req(0, 6'd1, '0, 4'h0, '0, "R2 read a1");
    // R3 partial merge
    do_req(1, 6'd2, 32'hAABBCCDD, 4'b0101, '0, "R3 partial write a2");
    do_req(0, 6'd2, '0, 4'h0, '0, "R3 read merged a2");
    // R5/R8 single flip on a data position; R9 no scrub keeps the error
    do_req(1, 6'd3, 32'hCAFEF00D, 4'hF, 39'(1) << 5, "R8 inject single a3");
    do_req(0, 6'd3, '0, 4'h0, '0, "R5 read single a3");
    check_last_log("R5 a3");
    do_req(0, 6'd3, '0, 4'h0, '0, "R9 reread unscrubbed a3");
    check_last_log("R9 a3 still flagged");
    // R9 scrub
    scrub_en = 1'b1;
    do_req(0, 6'd3, '0, 4'h0, '0, "R9 scrub read a3");
    do_req(0, 6'd3, '0, 4'h0, '0, "R9 clean after scrub a3");
    // R6 double error
    do_req(1, 6'd4, 32'h0F0F0F0F, 4'hF, (39'(1) << 3) | (39'(1) << 20), "R8 inject double a4");
    do_req(0, 6'd4, '0, 4'h0, '0, "R6 read double a4");
    check_last_log("R6 a4");
    do_req(0, 6'd4, '0, 4'h0, '0, "R9 double not scrubbed a4");
    do_req(1, 6'd4, 32'h000000FF, 4'b0001, '0, "R6 partial write on double a4");
    do_req(0, 6'd4, '0, 4'h0, '0, "R6 a4 unchanged after blocked write");
    // R3/R5 partial write on a word with parity-bit flip
    scrub_en = 1'b0;
    do_req(1, 6'd5, 32'h12345678, 4'hF, 39'(1), "R8 inject parity bit a5");
    do_req(1, 6'd5, 32'h9A000000, 4'b1000, '0, "R3 partial on single a5");
    check_last_log("R4 parity-bit syndrome a5");
    do_req(0, 6'd5, '0, 4'h0, '0, "R3 read a5 rewritten clean");
    // R8 injection on the write phase of a partial write
    do_req(1, 6'd6, 32'h55555555, 4'hF, '0, "R1 full write a6");
    do_req(1, 6'd6, 32'h0000ABCD, 4'b0011, 39'(1) << 38, "R8 partial write with injection a6");
    do_req(0, 6'd6, '0, 4'h0, '0, "R8 read a6 shows flip");
    check_last_log("R4 top position a6");
    // R7 wrap of the log
    for (int i = 0; i < 17; i++) do_req(0, 6'd4, '0, 4'h0, '0, "R7 wrap reads a4");
    check_last_log("R7 after wrap");
    idle(4);
    check(sb.size() == 0, "scoreboard drained", 64'(sb.size()), 64'h0);
    summary();
  end
endmodule